// File: doc/BRIEF.md
# Sector Erase Batch Window Timer

This block gathers several sector erase requests into a single concurrent erase. The command decoder reports a completed full erase sequence on `seq_done` together with the addressed sector. The block then opens an acceptance window. While it is open, each single-cycle erase command (`add_cmd`) aimed at a sector sets that sector's bit in a selection mask. Any write-enable falling edge (`we_fall`) or accepted command restarts the window.

When the window runs for `WIN_CYCLES` clock cycles with no restart, the selection is frozen. A one-cycle `erase_start` pulse then tells the erase engine to work on every marked sector at once. The engine reports completion on `engine_done`, and the block returns to idle with an empty mask.

The status bit `win_closed` lets software poll whether more sectors can still be added. `WIN_CYCLES` should equal 50 µs at the system clock frequency.

Top module: `sector_erase_window`

## Requirements
- R1: After reset the block is idle: `window_open`=0, `win_closed`=0, `erase_start`=0 and `sector_mask`=0. `window_open` and `win_closed` are never 1 together.
- R2: In idle, `seq_done` with a valid sector index k opens the window on the next clock edge with `sector_mask` equal to only bit k set.
- R3: If the window sees no accepted command and no `we_fall` for `WIN_CYCLES` consecutive cycles after its last restart, then on that edge `window_open` falls, `win_closed` rises and `erase_start` is 1 for exactly one cycle.
- R4: While the window is open, `add_cmd` or `seq_done` with valid index k sets bit k of `sector_mask`, keeps the other bits, and restarts the window count.
- R5: While the window is open, `we_fall` alone restarts the window count and leaves `sector_mask` unchanged.
- R6: While erasing (`win_closed`=1), `seq_done`, `add_cmd` and `we_fall` are ignored: `sector_mask` stays fixed and no new `erase_start` occurs.
- R7: Writing a sector already in the mask leaves `sector_mask` unchanged.
- R8: A sector index of `NUM_SECTORS` or above is ignored. In idle it opens no window. In the window it sets no bit, and it restarts the count only if `we_fall` is also present.
- R9: While erasing, `engine_done` returns the block to idle on the next edge, with `sector_mask`=0 and `win_closed`=0.
- R10: In idle, `add_cmd` alone is ignored and the block stays idle with an empty mask.
- R11: Sectors may be added in any order. Every index 0 to `NUM_SECTORS`-1, including the highest, maps to mask bit of the same number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_done | input | 1 | Full erase sequence completed (one-cycle pulse) |
| add_cmd | input | 1 | Single-cycle sector erase command (one-cycle pulse) |
| we_fall | input | 1 | Write-enable falling edge seen on the bus |
| sector_idx | input | IDX_W | Sector index of the current command |
| engine_done | input | 1 | Erase engine finished |
| window_open | output | 1 | Acceptance window is open |
| win_closed | output | 1 | Polling status: 1 once the erase has started |
| erase_start | output | 1 | One-cycle pulse launching the erase engine |
| sector_mask | output | NUM_SECTORS | Collected sector selection |

## Verification
Every input effect is registered once, so mask, window and status changes are due one clock edge after the cycle that presents the stimulus. Expiry is due exactly `WIN_CYCLES` edges after the last restart. The bench drives inputs on the falling edge and compares all outputs on the following falling edge. It checks them against a cycle model updated once per applied input set. Directed sequences probe the cycle just before and just at expiry, so an off-by-one in the window count is reported.

// File: rtl/sewin_pkg.sv
package sewin_pkg;
   typedef enum logic [1:0] {
      SEW_IDLE  = 2'd0,
      SEW_OPEN  = 2'd1,
      SEW_ERASE = 2'd2
   } sew_state_e;
endpackage

// File: rtl/sewin_decoder.sv
module sewin_decoder #(
   parameter int NUM_SECTORS = 19,
   parameter int IDX_W       = $clog2(NUM_SECTORS)
) (
   input  logic [IDX_W-1:0]       idx,
   output logic [NUM_SECTORS-1:0] onehot,
   output logic                   valid
);
   localparam int FULL_RANGE = (NUM_SECTORS == (1 << IDX_W)) ? 1 : 0;

   for (genvar i = 0; i < NUM_SECTORS; i++) begin : g_bit
      assign onehot[i] = (idx == IDX_W'(i));
   end

   if (FULL_RANGE == 1) begin : g_full
      assign valid = 1'b1;
   end else begin : g_part
      assign valid = (idx < IDX_W'(NUM_SECTORS));
   end

   // R8: an index is valid exactly when one decoded bit is set
   always_comb begin
      a_r8_decode_valid : assert (valid == ($countones(onehot) == 1));
   end
endmodule

// File: rtl/sewin_timer.sv
module sewin_timer #(
   parameter int WIN_CYCLES = 12500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic expire
);
   localparam int CW = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);

   logic [CW-1:0] cnt_q;

   assign expire = run && !clear && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear || expire || !run) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   a_r3_count_bound : assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);
   a_r5_clear_zero : assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (cnt_q == '0));
endmodule

// File: rtl/sector_erase_window.sv
module sector_erase_window #(
   parameter int NUM_SECTORS = 19,
   parameter int WIN_CYCLES  = 12500,
   parameter int IDX_W       = $clog2(NUM_SECTORS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   seq_done,
   input  logic                   add_cmd,
   input  logic                   we_fall,
   input  logic [IDX_W-1:0]       sector_idx,
   input  logic                   engine_done,
   output logic                   window_open,
   output logic                   win_closed,
   output logic                   erase_start,
   output logic [NUM_SECTORS-1:0] sector_mask
);
   import sewin_pkg::*;

   if (NUM_SECTORS < 2 || NUM_SECTORS > 64) begin : g_bad_ns
      $error("NUM_SECTORS out of range 2..64");
   end
   if (WIN_CYCLES < 2) begin : g_bad_win
      $error("WIN_CYCLES must be at least 2");
   end
   if (IDX_W != $clog2(NUM_SECTORS)) begin : g_bad_idx
      $error("IDX_W must equal clog2(NUM_SECTORS)");
   end

   sew_state_e             state_q;
   logic [NUM_SECTORS-1:0] mask_q;
   logic                   start_q;
   logic [NUM_SECTORS-1:0] sel_bit;
   logic                   idx_ok;
   logic                   accept;
   logic                   t_clear;
   logic                   t_run;
   logic                   t_expire;

   sewin_decoder #(.NUM_SECTORS(NUM_SECTORS), .IDX_W(IDX_W)) u_dec (
      .idx    (sector_idx),
      .onehot (sel_bit),
      .valid  (idx_ok)
   );

   assign accept  = (seq_done || add_cmd) && idx_ok;
   assign t_run   = (state_q == SEW_OPEN);
   assign t_clear = (state_q == SEW_IDLE && seq_done && idx_ok) ||
                    (state_q == SEW_OPEN && (accept || we_fall));

   sewin_timer #(.WIN_CYCLES(WIN_CYCLES)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (t_clear),
      .run    (t_run),
      .expire (t_expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEW_IDLE;
         mask_q  <= '0;
         start_q <= 1'b0;
      end else begin
         start_q <= 1'b0;
         unique case (state_q)
            SEW_IDLE: begin
               if (seq_done && idx_ok) begin
                  state_q <= SEW_OPEN;
                  mask_q  <= sel_bit;
               end
            end
            SEW_OPEN: begin
               if (accept) begin
                  mask_q <= mask_q | sel_bit;
               end
               if (t_expire) begin
                  state_q <= SEW_ERASE;
                  start_q <= 1'b1;
               end
            end
            SEW_ERASE: begin
               if (engine_done) begin
                  state_q <= SEW_IDLE;
                  mask_q  <= '0;
               end
            end
            default: state_q <= SEW_IDLE;
         endcase
      end
   end

   assign window_open = (state_q == SEW_OPEN);
   assign win_closed  = (state_q == SEW_ERASE);
   assign erase_start = start_q;
   assign sector_mask = mask_q;

   a_r1_exclusive : assert property (@(posedge clk) disable iff (!rst_n)
      !(window_open && win_closed));
   a_r2_first_bit : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(window_open) |-> ($countones(sector_mask) == 1));
   a_r3_start_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(win_closed) |-> erase_start);
   a_r3_start_once : assert property (@(posedge clk) disable iff (!rst_n)
      erase_start |=> !erase_start);
   a_r4_mask_grows : assert property (@(posedge clk) disable iff (!rst_n)
      (window_open && $past(window_open)) |->
      ((sector_mask & $past(sector_mask)) == $past(sector_mask)));
   a_r6_mask_frozen : assert property (@(posedge clk) disable iff (!rst_n)
      (win_closed && $past(win_closed)) |-> $stable(sector_mask));
   a_r9_back_idle : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(win_closed) |-> (sector_mask == '0 && !window_open));
endmodule

// File: tb/sector_erase_window_test.sv
`timescale 1ns/1ps
module sector_erase_window_test;
   localparam int NS = 19;
   localparam int W  = 16;
   localparam int IW = $clog2(NS);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic seq_done = 1'b0, add_cmd = 1'b0, we_fall = 1'b0, engine_done = 1'b0;
   logic [IW-1:0] sector_idx = '0;
   logic window_open, win_closed, erase_start;
   logic [NS-1:0] sector_mask;

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   int m_st = 0;
   int m_cnt = 0;
   logic [NS-1:0] m_mask = '0;
   bit m_start = 0;

   always #2 clk = ~clk;

   sector_erase_window #(.NUM_SECTORS(NS), .WIN_CYCLES(W)) uut (
      .clk(clk), .rst_n(rst_n), .seq_done(seq_done), .add_cmd(add_cmd),
      .we_fall(we_fall), .sector_idx(sector_idx), .engine_done(engine_done),
      .window_open(window_open), .win_closed(win_closed),
      .erase_start(erase_start), .sector_mask(sector_mask));

   function automatic logic [NS-1:0] bit_of(input int k);
      return NS'(1) << k;
   endfunction

   task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic model_step(input bit sd, input bit ad, input bit wf, input bit ed, input int idx);
      bit ok;
      bit acc;
      ok = (idx < NS);
      acc = (sd || ad) && ok;
      m_start = 0;
      case (m_st)
         0: if (sd && ok) begin m_st = 1; m_mask = bit_of(idx); m_cnt = 0; end
         1: begin
            if (acc || wf) begin
               if (acc) m_mask = m_mask | bit_of(idx);
               m_cnt = 0;
            end else if (m_cnt == W - 1) begin
               m_st = 2; m_start = 1; m_cnt = 0;
            end else m_cnt++;
         end
         default: if (ed) begin m_st = 0; m_mask = '0; end
      endcase
   endtask

   // Called at a falling edge: applies inputs, then compares at the next falling edge
   task automatic step(input string req, input bit sd, input bit ad, input bit wf,
                       input bit ed, input int idx);
      seq_done = sd; add_cmd = ad; we_fall = wf; engine_done = ed;
      sector_idx = IW'(idx);
      model_step(sd, ad, wf, ed, idx);
      @(negedge clk);
      seq_done = 0; add_cmd = 0; we_fall = 0; engine_done = 0;
      chk(req, {window_open, win_closed, erase_start, sector_mask},
          {(m_st == 1), (m_st == 2), m_start, m_mask});
   endtask

   task automatic idle_cycles(input string req, input int n);
      for (int i = 0; i < n; i++) step(req, 0, 0, 0, 0, 0);
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 reset", {window_open, win_closed, erase_start, sector_mask}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: add in idle ignored
      step("R10 add in idle", 0, 1, 1, 0, 3);
      chk("R10 mask empty", sector_mask, 0);
      // R8: out-of-range index opens nothing
      step("R8 bad idx idle", 1, 0, 1, 0, 25);
      chk("R8 still idle", window_open, 0);
      // R2: open window
      step("R2 open", 1, 0, 1, 0, 5);
      chk("R2 mask bit5", sector_mask, bit_of(5));
      idle_cycles("R4 wait", 4);
      step("R4 add sector0", 0, 1, 1, 0, 0);
      chk("R4 mask", sector_mask, bit_of(5) | bit_of(0));
      idle_cycles("R7 wait", 3);
      step("R7 duplicate", 0, 1, 1, 0, 5);
      chk("R7 mask unchanged", sector_mask, bit_of(5) | bit_of(0));
      step("R8 bad idx open", 0, 1, 0, 0, 30);
      chk("R8 no bit", sector_mask, bit_of(5) | bit_of(0));
      idle_cycles("R5 wait", W - 3);
      step("R5 we_fall restart", 0, 0, 1, 0, 0);
      chk("R5 mask same", sector_mask, bit_of(5) | bit_of(0));
      step("R11 top sector", 0, 1, 1, 0, NS - 1);
      chk("R11 mask top", sector_mask, bit_of(5) | bit_of(0) | bit_of(NS - 1));
      idle_cycles("R3 before expiry", W - 1);
      chk("R3 still open", {window_open, erase_start}, 2'b10);
      step("R3 expiry", 0, 0, 0, 0, 0);
      chk("R3 start pulse", {window_open, win_closed, erase_start}, 3'b011);
      step("R6 add ignored", 0, 1, 1, 0, 9);
      chk("R6 mask frozen", sector_mask, bit_of(5) | bit_of(0) | bit_of(NS - 1));
      chk("R6 no restart", erase_start, 0);
      step("R6 seq ignored", 1, 0, 1, 0, 2);
      idle_cycles("R6 hold", 5);
      step("R9 done", 0, 0, 0, 1, 0);
      chk("R9 idle", {window_open, win_closed, sector_mask}, 64'd0);
      // random phase against the cycle model
      for (int i = 0; i < 6000; i++) begin
         int r;
         bit sd, ad, wf, ed;
         r = $urandom_range(0, 99);
         sd = (r < 6);
         ad = (r >= 6 && r < 10);
         wf = (sd || ad) ? 1'b1 : ($urandom_range(0, 99) < 2);
         ed = (m_st == 2) && ($urandom_range(0, 99) < 8);
         step("R4 random", sd, ad, wf, ed, $urandom_range(0, 31));
      end
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule